// File: doc/BRIEF.md
# Segment Access Protection Checker

This block vets a single memory access against the cached copy of a segment descriptor. The access arrives as an offset, a size in bytes and a kind: instruction fetch, data read or data write. The descriptor arrives alongside it as a base, a limit, an expand-down flag, a present bit, an executable bit, a read/write bit and a descriptor privilege level. The selector's requested privilege, the current privilege level and the protected-mode enable complete the input set.

One cycle after a valid strobe, the block returns a fault code and an ok flag. When the access is clean it also returns a linear address equal to base plus offset. The bound checks run in every mode. The presence, privilege and type checks run only when protected mode is enabled.

When several checks would fail, only the first in a fixed order is reported. A faulting access leaves the linear-address output untouched.

Top module: `seg_access_guard`

## Requirements
- R1: A response is registered exactly one cycle after each `req_valid` cycle (`rsp_valid` high for that cycle only). With no request, the next cycle shows `rsp_valid`=0, `rsp_ok`=0 and `rsp_fault`=0.
- R2: For an instruction fetch, or for an access to a segment whose expand-down flag is clear, the block reports a general-protection fault (code 1) when offset + size - 1, evaluated in ADDR_W+1 bits so it cannot wrap, exceeds the limit. Legal sizes are 1, 2 and 4.
- R3: For a data read or write to an expand-down segment, the block reports a general-protection fault when the offset is below the limit. An offset equal to the limit passes. Instruction fetches ignore the expand-down flag.
- R4: With `prot_en`=0, only the checks of R2 and R3 apply, and every other descriptor field has no effect on the result.
- R5: In protected mode, a descriptor whose present bit is clear yields the not-present fault (code 2).
- R6: In protected mode, CPL > DPL is a general-protection fault. For data reads and writes (but not fetches), RPL > DPL is also a general-protection fault.
- R7: In protected mode, a fetch from a segment with the executable bit clear is a general-protection fault. So is a data read from an executable segment whose read/write bit is clear.
- R8: In protected mode, a write to an executable segment, or to a data segment whose read/write bit is clear, is a general-protection fault.
- R9: A clean access (code 0) sets `rsp_ok`=1 and `rsp_linear` = (base + offset) mod 2^ADDR_W.
- R10: Faults are checked in this priority order: bound (R2/R3), then presence (R5), then privilege (R6), then type (R7/R8). Only the first failing check is reported.
- R11: On a faulting response, `rsp_ok` is 0 and `rsp_linear` keeps its previous value.
- R12: During reset, all outputs are 0.
- Encodings: `req_kind` is 0 for fetch, 1 for read and 2 for write; `rsp_fault` is 0 for none, 1 for general protection and 2 for not present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe |
| req_kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write |
| req_offset | input | ADDR_W | Offset within the segment |
| req_size | input | SIZE_W | Access size in bytes (1, 2 or 4) |
| desc_base | input | ADDR_W | Segment base |
| desc_limit | input | ADDR_W | Segment limit |
| desc_expand_down | input | 1 | Segment grows downward |
| desc_present | input | 1 | Descriptor present bit |
| desc_exec | input | 1 | Segment holds code |
| desc_rw | input | 1 | Readable (code) or writable (data) |
| desc_dpl | input | PRIV_W | Descriptor privilege level |
| sel_rpl | input | PRIV_W | Requested privilege level of the selector |
| cur_cpl | input | PRIV_W | Current privilege level |
| prot_en | input | 1 | Protected mode enable |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 2 | Fault code: 0 none, 1 general protection, 2 not present |
| rsp_ok | output | 1 | Access passed every check |
| rsp_linear | output | ADDR_W | Linear address of the last clean access |

## Verification
The bench uses the default parameters: ADDR_W=32, SIZE_W=3 and PRIV_W=2. With 32-bit addresses, directed cases can reach the all-ones offset, where a 4-byte access only overflows if the end address gains a 33rd bit. The same width covers a base plus offset that wraps past 2^32. With two-bit privilege fields, random draws cover every CPL, RPL and DPL ordering. Random offsets are drawn close to the limit, so both the normal and the expand-down boundaries are crossed in each direction.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_GP   = 2'd1,
      FLT_NP   = 2'd2,
      FLT_RSVD = 2'd3
   } fault_e;

endpackage

// File: rtl/seg_bound_check.sv
module seg_bound_check
   import seg_guard_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 3
) (
   input  acc_kind_e          kind,
   input  logic [ADDR_W-1:0]  offset,
   input  logic [SIZE_W-1:0]  size,
   input  logic [ADDR_W-1:0]  limit,
   input  logic               expand_down,
   output logic               bound_fault
);
   localparam int EXT_W = ADDR_W + 1;

   logic [EXT_W-1:0] last_byte;
   logic [EXT_W-1:0] limit_ext;
   logic             upward_rule;
   logic             over_top;
   logic             under_floor;

   generate
      if (SIZE_W >= EXT_W) begin : g_size_err
         $error("seg_bound_check: SIZE_W must be narrower than ADDR_W+1");
      end
   endgenerate

   always_comb begin
      last_byte   = {1'b0, offset} + EXT_W'(size) - EXT_W'(1);
      limit_ext   = {1'b0, limit};
      upward_rule = (kind == ACC_FETCH) || !expand_down;
      over_top    = last_byte > limit_ext;
      under_floor = offset < limit;
      bound_fault = upward_rule ? over_top : under_floor;
   end

endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check
   import seg_guard_pkg::*;
#(
   parameter int PRIV_W = 2
) (
   input  acc_kind_e          kind,
   input  logic [PRIV_W-1:0]  cpl,
   input  logic [PRIV_W-1:0]  rpl,
   input  logic [PRIV_W-1:0]  dpl,
   output logic               priv_fault
);
   logic cpl_bad;
   logic rpl_bad;

   always_comb begin
      cpl_bad    = cpl > dpl;
      rpl_bad    = (kind != ACC_FETCH) && (rpl > dpl);
      priv_fault = cpl_bad || rpl_bad;
   end

endmodule

// File: rtl/seg_type_check.sv
module seg_type_check
   import seg_guard_pkg::*;
(
   input  acc_kind_e  kind,
   input  logic       exec,
   input  logic       rw,
   output logic       type_fault
);
   always_comb begin
      unique case (kind)
         ACC_FETCH: type_fault = !exec;
         ACC_WRITE: type_fault = exec || !rw;
         default:   type_fault = exec && !rw;
      endcase
   end

endmodule

// File: rtl/seg_access_guard.sv
module seg_access_guard
   import seg_guard_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 3,
   parameter int PRIV_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_kind,
   input  logic [ADDR_W-1:0]  req_offset,
   input  logic [SIZE_W-1:0]  req_size,
   input  logic [ADDR_W-1:0]  desc_base,
   input  logic [ADDR_W-1:0]  desc_limit,
   input  logic               desc_expand_down,
   input  logic               desc_present,
   input  logic               desc_exec,
   input  logic               desc_rw,
   input  logic [PRIV_W-1:0]  desc_dpl,
   input  logic [PRIV_W-1:0]  sel_rpl,
   input  logic [PRIV_W-1:0]  cur_cpl,
   input  logic               prot_en,
   output logic               rsp_valid,
   output logic [1:0]         rsp_fault,
   output logic               rsp_ok,
   output logic [ADDR_W-1:0]  rsp_linear
);
   generate
      if (ADDR_W < 8) begin : g_addr_err
         $error("seg_access_guard: ADDR_W must be at least 8");
      end
      if (SIZE_W < 3) begin : g_size_err
         $error("seg_access_guard: SIZE_W must hold the value 4");
      end
      if (PRIV_W < 1) begin : g_priv_err
         $error("seg_access_guard: PRIV_W must be positive");
      end
   endgenerate

   acc_kind_e         kind;
   logic              bound_fault;
   logic              priv_fault;
   logic              type_fault;
   fault_e            verdict;
   logic [ADDR_W-1:0] lin_sum;

   assign kind = acc_kind_e'(req_kind);

   seg_bound_check #(
      .ADDR_W (ADDR_W),
      .SIZE_W (SIZE_W)
   ) i_bound (
      .kind        (kind),
      .offset      (req_offset),
      .size        (req_size),
      .limit       (desc_limit),
      .expand_down (desc_expand_down),
      .bound_fault (bound_fault)
   );

   seg_rights_check #(
      .PRIV_W (PRIV_W)
   ) i_rights (
      .kind       (kind),
      .cpl        (cur_cpl),
      .rpl        (sel_rpl),
      .dpl        (desc_dpl),
      .priv_fault (priv_fault)
   );

   seg_type_check i_type (
      .kind       (kind),
      .exec       (desc_exec),
      .rw         (desc_rw),
      .type_fault (type_fault)
   );

   // Fixed priority: bound, presence, privilege, type.
   always_comb begin
      if (bound_fault)        verdict = FLT_GP;
      else if (!prot_en)      verdict = FLT_NONE;
      else if (!desc_present) verdict = FLT_NP;
      else if (priv_fault)    verdict = FLT_GP;
      else if (type_fault)    verdict = FLT_GP;
      else                    verdict = FLT_NONE;
      lin_sum = desc_base + req_offset;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_fault  <= FLT_NONE;
         rsp_ok     <= 1'b0;
         rsp_linear <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_fault <= verdict;
            rsp_ok    <= (verdict == FLT_NONE);
            if (verdict == FLT_NONE) rsp_linear <= lin_sum;
         end else begin
            rsp_fault <= FLT_NONE;
            rsp_ok    <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/seg_access_guard_chk.sv
module seg_access_guard_chk #(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 3,
   parameter int PRIV_W = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [1:0]         req_kind,
   input logic [ADDR_W-1:0]  req_offset,
   input logic [SIZE_W-1:0]  req_size,
   input logic [ADDR_W-1:0]  desc_base,
   input logic               desc_present,
   input logic [PRIV_W-1:0]  cur_cpl,
   input logic [PRIV_W-1:0]  desc_dpl,
   input logic               prot_en,
   input logic               rsp_valid,
   input logic [1:0]         rsp_fault,
   input logic               rsp_ok,
   input logic [ADDR_W-1:0]  rsp_linear
);
   p_resp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_ok && rsp_fault == 2'd0));

   p_size_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_size == 1 || req_size == 2 || req_size == 4));

   p_real_no_np_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !$past(prot_en)) |-> (rsp_fault != 2'd2));

   p_present_no_np_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(desc_present)) |-> (rsp_fault != 2'd2));

   p_cpl_over_dpl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(prot_en && desc_present && cur_cpl > desc_dpl)) |-> !rsp_ok);

   p_linear_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ok) |-> (rsp_linear == ADDR_W'($past(desc_base) + $past(req_offset))));

   p_fault_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'd0) |-> (!rsp_ok && $stable(rsp_linear)));

   p_code_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault != 2'd3);

   p_kind_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_kind != 2'd3));

endmodule

bind seg_access_guard seg_access_guard_chk #(
   .ADDR_W (ADDR_W),
   .SIZE_W (SIZE_W),
   .PRIV_W (PRIV_W)
) i_seg_access_guard_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_kind     (req_kind),
   .req_offset   (req_offset),
   .req_size     (req_size),
   .desc_base    (desc_base),
   .desc_present (desc_present),
   .cur_cpl      (cur_cpl),
   .desc_dpl     (desc_dpl),
   .prot_en      (prot_en),
   .rsp_valid    (rsp_valid),
   .rsp_fault    (rsp_fault),
   .rsp_ok       (rsp_ok),
   .rsp_linear   (rsp_linear)
);

// File: tb/test_seg_access_guard.sv
`timescale 1ns/1ps
module test_seg_access_guard;
   localparam int AW = 32;
   localparam int SW = 3;
   localparam int PW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = '0;
   logic [AW-1:0] req_offset = '0;
   logic [SW-1:0] req_size = 3'd1;
   logic [AW-1:0] desc_base = '0;
   logic [AW-1:0] desc_limit = '0;
   logic          desc_expand_down = 1'b0;
   logic          desc_present = 1'b0;
   logic          desc_exec = 1'b0;
   logic          desc_rw = 1'b0;
   logic [PW-1:0] desc_dpl = '0;
   logic [PW-1:0] sel_rpl = '0;
   logic [PW-1:0] cur_cpl = '0;
   logic          prot_en = 1'b0;
   logic          rsp_valid;
   logic [1:0]    rsp_fault;
   logic          rsp_ok;
   logic [AW-1:0] rsp_linear;

   int checks = 0;
   int errors = 0;
   logic [AW-1:0] exp_lin = '0;
   bit done = 0;

   always #2 clk = ~clk;

   seg_access_guard #(.ADDR_W(AW), .SIZE_W(SW), .PRIV_W(PW)) i_seg_access_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_offset(req_offset), .req_size(req_size), .desc_base(desc_base),
      .desc_limit(desc_limit), .desc_expand_down(desc_expand_down),
      .desc_present(desc_present), .desc_exec(desc_exec), .desc_rw(desc_rw),
      .desc_dpl(desc_dpl), .sel_rpl(sel_rpl), .cur_cpl(cur_cpl), .prot_en(prot_en),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_ok(rsp_ok),
      .rsp_linear(rsp_linear)
   );

   function automatic logic [1:0] model(output string tag);
      logic [AW:0] last;
      last = {1'b0, req_offset} + (AW+1)'(req_size) - (AW+1)'(1);
      if (req_kind == 2'd0 || !desc_expand_down) begin
         if (last > {1'b0, desc_limit}) begin tag = "R2"; return 2'd1; end
      end else if (req_offset < desc_limit) begin
         tag = "R3"; return 2'd1;
      end
      if (!prot_en) begin tag = "R4"; return 2'd0; end
      if (!desc_present) begin tag = "R5"; return 2'd2; end
      if (cur_cpl > desc_dpl || (req_kind != 2'd0 && sel_rpl > desc_dpl)) begin
         tag = "R6"; return 2'd1;
      end
      if (req_kind == 2'd0 && !desc_exec) begin tag = "R7"; return 2'd1; end
      if (req_kind == 2'd1 && desc_exec && !desc_rw) begin tag = "R7"; return 2'd1; end
      if (req_kind == 2'd2 && (desc_exec || !desc_rw)) begin tag = "R8"; return 2'd1; end
      tag = "R9";
      return 2'd0;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   // Called at a negedge with inputs already set; checks the registered result.
   task automatic run_access(input string force_tag);
      string tag;
      logic [1:0] ef;
      logic [AW-1:0] sum;
      ef = model(tag);
      sum = desc_base + req_offset;
      if (force_tag != "") tag = force_tag;
      req_valid = 1'b1;
      @(negedge clk);
      if (ef == 2'd0) exp_lin = sum;
      check({tag, " valid R1"}, 64'(rsp_valid), 64'd1);
      check({tag, " fault"}, 64'(rsp_fault), 64'(ef));
      check({tag, " ok R11"}, 64'(rsp_ok), 64'(ef == 2'd0));
      check({tag, " linear R9"}, 64'(rsp_linear), 64'(exp_lin));
   endtask

   task automatic set_desc(input logic [AW-1:0] b, input logic [AW-1:0] l, input logic ed,
                           input logic pr, input logic ex, input logic rw,
                           input logic [PW-1:0] dpl, input logic [PW-1:0] rpl,
                           input logic [PW-1:0] cpl, input logic pe);
      desc_base = b; desc_limit = l; desc_expand_down = ed; desc_present = pr;
      desc_exec = ex; desc_rw = rw; desc_dpl = dpl; sel_rpl = rpl; cur_cpl = cpl; prot_en = pe;
   endtask

   task automatic set_req(input logic [1:0] k, input logic [AW-1:0] off, input logic [SW-1:0] sz);
      req_kind = k; req_offset = off; req_size = sz;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [SW-1:0] sizes [3];
      sizes[0] = 3'd1; sizes[1] = 3'd2; sizes[2] = 3'd4;
      void'($urandom(32'h1BADC0DE));
      repeat (3) @(negedge clk);
      check("R12 valid", 64'(rsp_valid), 64'd0);
      check("R12 fault", 64'(rsp_fault), 64'd0);
      check("R12 ok", 64'(rsp_ok), 64'd0);
      check("R12 linear", 64'(rsp_linear), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Directed: clean data read, last byte exactly at limit
      set_desc(32'h1000, 32'hFF, 0, 1, 0, 1, 2'd3, 2'd3, 2'd3, 1);
      set_req(2'd1, 32'hFC, 3'd4);
      run_access("R2 edge ok");
      set_req(2'd1, 32'hFD, 3'd4);
      run_access("R2 edge over");
      // 33-bit end address at top of space
      set_desc(32'h0, 32'hFFFF_FFFF, 0, 1, 0, 1, 2'd0, 2'd0, 2'd0, 1);
      set_req(2'd1, 32'hFFFF_FFFD, 3'd4);
      run_access("R2 no wrap");
      // base + offset wraps
      set_desc(32'hFFFF_FF00, 32'hFFFF_FFFF, 0, 1, 0, 1, 2'd0, 2'd0, 2'd0, 1);
      set_req(2'd2, 32'h0000_0200, 3'd2);
      run_access("R9 wrap");
      // Expand-down: offset equal to limit passes, below faults, fetch ignores flag
      set_desc(32'h40, 32'h800, 1, 1, 0, 1, 2'd0, 2'd0, 2'd0, 1);
      set_req(2'd1, 32'h800, 3'd1);
      run_access("R3 equal");
      set_req(2'd2, 32'h7FF, 3'd1);
      run_access("R3 below");
      set_desc(32'h40, 32'h800, 1, 1, 1, 1, 2'd0, 2'd0, 2'd0, 1);
      set_req(2'd0, 32'h10, 3'd4);
      run_access("R3 fetch");
      // Real mode ignores presence and type
      set_desc(32'h500, 32'hFFFF, 0, 0, 1, 0, 2'd0, 2'd3, 2'd3, 0);
      set_req(2'd2, 32'h20, 3'd2);
      run_access("R4 real");
      // Priority: bound beats not-present; not-present beats privilege
      set_desc(32'h0, 32'h10, 0, 0, 0, 0, 2'd0, 2'd3, 2'd3, 1);
      set_req(2'd2, 32'h20, 3'd1);
      run_access("R10 bound first");
      set_req(2'd2, 32'h4, 3'd1);
      run_access("R10 np first");
      // Fetch skips RPL test; read does not
      set_desc(32'h0, 32'hFFF, 0, 1, 1, 1, 2'd1, 2'd3, 2'd0, 1);
      set_req(2'd0, 32'h4, 3'd1);
      run_access("R6 fetch rpl");
      set_req(2'd1, 32'h4, 3'd1);
      run_access("R6 read rpl");
      // Execute-only read, code write
      set_desc(32'h0, 32'hFFF, 0, 1, 1, 0, 2'd0, 2'd0, 2'd0, 1);
      set_req(2'd1, 32'h4, 3'd1);
      run_access("R7 exec only");
      set_req(2'd2, 32'h4, 3'd1);
      run_access("R8 code write");
      // Idle cycle
      req_valid = 1'b0;
      @(negedge clk);
      check("R1 idle valid", 64'(rsp_valid), 64'd0);
      check("R1 idle ok", 64'(rsp_ok), 64'd0);
      check("R11 idle linear", 64'(rsp_linear), 64'(exp_lin));

      // Random accesses near the limit
      for (int n = 0; n < 3000; n++) begin
         logic [AW-1:0] lim;
         lim = $urandom;
         set_desc($urandom, lim, 1'($urandom), ($urandom % 8) != 0, 1'($urandom),
                  1'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
                  ($urandom % 6) != 0);
         set_req(2'($urandom % 3), lim + AW'($urandom % 9) - AW'(4), sizes[$urandom % 3]);
         if (($urandom % 4) == 0) req_offset = $urandom;
         run_access("");
         if (($urandom % 10) == 0) begin
            req_valid = 1'b0;
            @(negedge clk);
            check("R1 gap", 64'(rsp_valid), 64'd0);
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule